// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets a host controller reach an on-chip register file through a two-wire asynchronous serial link. The link has one receive line into the block and one transmit line out of it. Every frame is sent at a fixed 4800 bit/s. The block turns incoming frames into bytes and reads them as a command packet. The first byte of a packet names the operation. The next two bytes carry a 16-bit register address, with the high byte first.

A write packet is followed by four data bytes. Once all four bytes have arrived, the block issues one write strobe on a simple register bus. For a read packet, the block strobes the register bus and samples the returned word. It then sends that word back as four frames, lowest byte first. Silence between the frames of a packet resynchronizes the parser, and so does a corrupted frame. After each completed operation, the block keeps a record of its address, its data and its kind on dedicated output ports.

The bit period is `CLK_HZ / BAUD` system clock cycles, and `CLK_HZ` is a parameter. The inter-frame timeout is `(CLK_HZ/1000) * T1_MS` cycles. The bench uses `CLK_HZ = 76800`, which gives 16 cycles per bit and a timeout of 304 cycles.

Top module: `serial_reg_slave`

## Requirements
- R1: Each frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Every bit lasts `CLK_HZ/BAUD` clock cycles. The transmit line rests high whenever no response is being sent.
- R2: The opcode byte 0x35 selects a read. After the address-high and address-low frames, `reg_rd` is high for exactly one cycle, and during that cycle `reg_addr` equals {high byte, low byte}.
- R3: The opcode byte 0xCA selects a write. After the two address frames, four data frames follow, least significant byte first. After the fourth frame, `reg_wr` pulses for exactly one cycle, with `reg_addr` set to the address and `reg_wdata` set to the assembled 32-bit word.
- R4: Any opcode byte other than 0x35 or 0xCA starts no transaction. It causes no `reg_rd` and no `reg_wr`, and it leaves the last-operation ports unchanged. The next frame is again treated as an opcode.
- R5: On a read, `reg_rdata` is sampled in the cycle after `reg_rd`. It is sent on `tx` as four frames, least significant byte first. The first start bit begins no later than one bit period after the stop bit of the address-low frame ends.
- R6: If the line stays idle for longer than the timeout (4 ms) between two frames of one packet, the packet is abandoned without any register access. The next frame is treated as an opcode.
- R7: Gaps between the frames of a packet that are shorter than the timeout do not disturb the transaction.
- R8: A frame whose stop bit is sampled low is a framing error. It abandons the packet without any register access and without changing the last-operation ports.
- R9: After each successful operation, `last_addr` holds the address, `last_data` holds the data word, and `last_op` holds the kind. The encoding of `last_op` is 0 for none, 1 for read and 2 for write. The ports change only as the result of a successful operation.
- R10: While reset is held, and in the cycle after it, `tx` is high, both strobes are low, and `last_op`, `last_addr` and `last_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx | input | 1 | Serial receive line from the host |
| tx | output | 1 | Serial transmit line to the host |
| reg_addr | output | 16 | Register bus address |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | DW | Write data, valid with `reg_wr` |
| reg_rdata | input | DW | Read data, sampled the cycle after `reg_rd` |
| last_addr | output | 16 | Address of the last successful operation |
| last_data | output | DW | Data of the last successful operation |
| last_op | output | 2 | Kind of the last successful operation |

## Verification
The assertions check the following on every cycle:
- the strobes are single-cycle and never high together;
- the last-operation record changes only together with a write strobe, or two cycles after a read strobe;
- the silence counter never reaches the timeout value;
- a framing error always returns the parser to the opcode state;
- the transmit line is idle outside the response state.

Only the bench scenarios can show the rest:
- the byte order on the wire and the assembled data words;
- the response latency;
- which of the 254 invalid opcode values is rejected;
- that a gap just under the timeout keeps a packet alive while a longer gap kills it.

// File: rtl/srs_pkg.sv
package srs_pkg;

    localparam logic [7:0] OPC_READ  = 8'h35;
    localparam logic [7:0] OPC_WRITE = 8'hCA;

    typedef enum logic [1:0] {
        OPK_NONE  = 2'd0,
        OPK_READ  = 2'd1,
        OPK_WRITE = 2'd2
    } op_kind_e;

    typedef enum logic [2:0] {
        P_OP,
        P_AH,
        P_AL,
        P_WDATA,
        P_RDREQ,
        P_RDCAP,
        P_TX
    } pstate_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAITHI
    } rxstate_e;

    function automatic op_kind_e decode_opcode(input logic [7:0] b);
        case (b)
            OPC_READ:  return OPK_READ;
            OPC_WRITE: return OPK_WRITE;
            default:   return OPK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/srs_rx.sv
module srs_rx
    import srs_pkg::*;
#(
    parameter int BIT_CYC = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line,
    output logic       done,
    output logic       err,
    output logic [7:0] data,
    output logic       busy
);
    localparam int CW   = $clog2(BIT_CYC);
    localparam int HALF = BIT_CYC / 2;

    logic           line_m, line_s;
    rxstate_e       st;
    logic [CW-1:0]  cnt;
    logic [2:0]     bitn;
    logic [7:0]     sh;

    assign busy = (st != RX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_m <= 1'b1;
            line_s <= 1'b1;
            st     <= RX_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            sh     <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
            data   <= '0;
        end else begin
            line_m <= line;
            line_s <= line_m;
            done   <= 1'b0;
            case (st)
                RX_IDLE: begin
                    cnt <= '0;
                    if (!line_s) st <= RX_START;
                end
                RX_START: begin
                    if (cnt == CW'(HALF - 1)) begin
                        cnt  <= '0;
                        bitn <= '0;
                        st   <= line_s ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == CW'(BIT_CYC - 1)) begin
                        cnt  <= '0;
                        sh   <= {line_s, sh[7:1]};
                        bitn <= bitn + 1'b1;
                        if (bitn == 3'd7) st <= RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == CW'(BIT_CYC - 1)) begin
                        cnt  <= '0;
                        done <= 1'b1;
                        err  <= !line_s;
                        data <= sh;
                        st   <= line_s ? RX_IDLE : RX_WAITHI;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_WAITHI: begin
                    if (line_s) st <= RX_IDLE;
                end
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/srs_tx.sv
module srs_tx #(
    parameter int BIT_CYC = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] din,
    output logic       line,
    output logic       done
);
    localparam int CW = $clog2(BIT_CYC);

    logic [9:0]    sh;
    logic          active;
    logic [CW-1:0] cnt;
    logic [3:0]    bitn;

    assign line = sh[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '1;
            active <= 1'b0;
            cnt    <= '0;
            bitn   <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (go) begin
                    sh     <= {1'b1, din, 1'b0};
                    active <= 1'b1;
                    cnt    <= '0;
                    bitn   <= '0;
                end
            end else if (cnt == CW'(BIT_CYC - 1)) begin
                cnt <= '0;
                sh  <= {1'b1, sh[9:1]};
                if (bitn == 4'd9) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    bitn <= bitn + 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave
    import srs_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 4800,
    parameter int T1_MS  = 4,
    parameter int DW     = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx,
    output logic          tx,
    output logic [15:0]   reg_addr,
    output logic          reg_rd,
    output logic          reg_wr,
    output logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] reg_rdata,
    output logic [15:0]   last_addr,
    output logic [DW-1:0] last_data,
    output logic [1:0]    last_op
);
    localparam int BIT_CYC = CLK_HZ / BAUD;
    localparam int T1_CYC  = (CLK_HZ / 1000) * T1_MS;
    localparam int NB      = DW / 8;
    localparam int BW      = (NB > 1) ? $clog2(NB) : 1;
    localparam int GW      = $clog2(T1_CYC + 1);

    logic          fr_done, fr_err, rx_busy;
    logic [7:0]    fr_byte;
    logic          tx_go, tx_done;

    pstate_e       state;
    op_kind_e      opk, last_op_q;
    logic [15:0]   addr_q;
    logic [BW-1:0] wcnt, bidx;
    logic [DW-1:0] wdata_q, rdbuf;
    logic [GW-1:0] gap_cnt;
    logic          gap_run, timeout;
    logic [DW-1:0] wd_next;

    srs_rx #(.BIT_CYC(BIT_CYC)) i_rx (
        .clk(clk), .rst(rst), .line(rx),
        .done(fr_done), .err(fr_err), .data(fr_byte), .busy(rx_busy)
    );

    srs_tx #(.BIT_CYC(BIT_CYC)) i_tx (
        .clk(clk), .rst(rst), .go(tx_go), .din(rdbuf[7:0]),
        .line(tx), .done(tx_done)
    );

    assign gap_run   = (state == P_AH || state == P_AL || state == P_WDATA) && !rx_busy;
    assign timeout   = gap_run && (gap_cnt == GW'(T1_CYC - 1));
    assign wd_next   = {fr_byte, wdata_q[DW-1:8]};
    assign reg_rd    = (state == P_RDREQ);
    assign reg_addr  = addr_q;
    assign reg_wdata = wdata_q;
    assign last_op   = last_op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= P_OP;
            opk       <= OPK_NONE;
            addr_q    <= '0;
            wcnt      <= '0;
            bidx      <= '0;
            wdata_q   <= '0;
            rdbuf     <= '0;
            gap_cnt   <= '0;
            reg_wr    <= 1'b0;
            tx_go     <= 1'b0;
            last_addr <= '0;
            last_data <= '0;
            last_op_q <= OPK_NONE;
        end else begin
            reg_wr <= 1'b0;
            tx_go  <= 1'b0;
            if (!gap_run || timeout) gap_cnt <= '0;
            else                     gap_cnt <= gap_cnt + 1'b1;

            case (state)
                P_OP: begin
                    if (fr_done && !fr_err) begin
                        opk <= decode_opcode(fr_byte);
                        if (decode_opcode(fr_byte) != OPK_NONE) state <= P_AH;
                    end
                end
                P_AH: begin
                    if (timeout) state <= P_OP;
                    else if (fr_done) begin
                        if (fr_err) state <= P_OP;
                        else begin
                            addr_q[15:8] <= fr_byte;
                            state        <= P_AL;
                        end
                    end
                end
                P_AL: begin
                    if (timeout) state <= P_OP;
                    else if (fr_done) begin
                        if (fr_err) state <= P_OP;
                        else begin
                            addr_q[7:0] <= fr_byte;
                            wcnt        <= '0;
                            state       <= (opk == OPK_READ) ? P_RDREQ : P_WDATA;
                        end
                    end
                end
                P_WDATA: begin
                    if (timeout) state <= P_OP;
                    else if (fr_done) begin
                        if (fr_err) state <= P_OP;
                        else begin
                            wdata_q <= wd_next;
                            if (wcnt == BW'(NB - 1)) begin
                                reg_wr    <= 1'b1;
                                last_op_q <= OPK_WRITE;
                                last_addr <= addr_q;
                                last_data <= wd_next;
                                state     <= P_OP;
                            end else begin
                                wcnt <= wcnt + 1'b1;
                            end
                        end
                    end
                end
                P_RDREQ: state <= P_RDCAP;
                P_RDCAP: begin
                    rdbuf     <= reg_rdata;
                    last_data <= reg_rdata;
                    last_addr <= addr_q;
                    last_op_q <= OPK_READ;
                    tx_go     <= 1'b1;
                    bidx      <= '0;
                    state     <= P_TX;
                end
                P_TX: begin
                    if (tx_done) begin
                        if (bidx == BW'(NB - 1)) state <= P_OP;
                        else begin
                            rdbuf <= rdbuf >> 8;
                            bidx  <= bidx + 1'b1;
                            tx_go <= 1'b1;
                        end
                    end
                end
                default: state <= P_OP;
            endcase
        end
    end
endmodule

// File: rtl/srs_checker.sv
module srs_checker
    import srs_pkg::*;
#(
    parameter int T1_CYC = 304,
    parameter int GW     = 9,
    parameter int DW     = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          tx,
    input logic          reg_rd,
    input logic          reg_wr,
    input logic [15:0]   reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [15:0]   last_addr,
    input logic [DW-1:0] last_data,
    input logic [1:0]    last_op,
    input logic [GW-1:0] gap_cnt,
    input pstate_e       state,
    input logic          fr_done,
    input logic          fr_err
);
    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst) reg_rd |=> !reg_rd); // R2
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst) reg_wr |=> !reg_wr); // R3
    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst) !(reg_rd && reg_wr)); // R4
    AST_WR_LOGGED: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> (last_op == 2'd2 && last_addr == reg_addr && last_data == reg_wdata)); // R9
    AST_LOG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (!$stable(last_op) || !$stable(last_addr) || !$stable(last_data)) |-> (reg_wr || $past(reg_rd, 2))); // R9
    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst) gap_cnt < GW'(T1_CYC)); // R6
    AST_FRAME_ERR_ABORT: assert property (@(posedge clk) disable iff (rst)
        (fr_done && fr_err && (state == P_AH || state == P_AL || state == P_WDATA)) |=> (state == P_OP && !reg_wr)); // R8
    AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst) (state != P_TX) |-> tx); // R1
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (tx && !reg_wr && !reg_rd && last_op == 2'd0)); // R10
endmodule

bind serial_reg_slave srs_checker #(.T1_CYC(T1_CYC), .GW(GW), .DW(DW)) i_chk (
    .clk(clk), .rst(rst), .tx(tx), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .last_addr(last_addr),
    .last_data(last_data), .last_op(last_op), .gap_cnt(gap_cnt),
    .state(state), .fr_done(fr_done), .fr_err(fr_err)
);

// File: tb/test_serial_reg_slave.sv
module test_serial_reg_slave;
    localparam int CLK_HZ = 76800;
    localparam int BAUD   = 4800;
    localparam int BIT    = CLK_HZ / BAUD;
    localparam int T1     = (CLK_HZ / 1000) * 4;
    localparam int PGAP   = 500;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx  = 1'b1;
    logic        tx;
    logic [15:0] reg_addr, last_addr;
    logic        reg_rd, reg_wr;
    logic [31:0] reg_wdata, reg_rdata, last_data;
    logic [1:0]  last_op;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int wr_cnt = 0, rd_cnt = 0;
    logic [15:0] wr_addr_seen, rd_addr_seen;
    logic [31:0] wr_data_seen;
    int tx_n = 0;
    int tx_first = 0;
    int t_end = 0;
    logic [7:0] tx_bytes [0:15];
    logic tx_stop_ok = 1'b1;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] model(input logic [15:0] a);
        return {a ^ 16'hC3A5, ~a};
    endfunction
    assign reg_rdata = model(reg_addr);

    serial_reg_slave #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) i_serial_reg_slave (
        .clk(clk), .rst(rst), .rx(rx), .tx(tx), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .last_addr(last_addr), .last_data(last_data),
        .last_op(last_op)
    );

    always @(negedge clk) begin
        if (reg_wr) begin
            wr_cnt       <= wr_cnt + 1;
            wr_addr_seen <= reg_addr;
            wr_data_seen <= reg_wdata;
        end
        if (reg_rd) begin
            rd_cnt       <= rd_cnt + 1;
            rd_addr_seen <= reg_addr;
        end
    end

    initial begin
        logic [7:0] b;
        wait (!rst);
        forever begin
            @(negedge clk);
            if (tx == 1'b0) begin
                if (tx_n == 0) tx_first = cyc;
                repeat (BIT / 2) @(negedge clk);
                for (int k = 0; k < 8; k++) begin
                    repeat (BIT) @(negedge clk);
                    b[k] = tx;
                end
                repeat (BIT) @(negedge clk);
                if (!tx) tx_stop_ok = 1'b0;
                if (tx_n < 16) tx_bytes[tx_n] = b;
                tx_n = tx_n + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit good_stop);
        rx = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rx = b[k];
            repeat (BIT) @(negedge clk);
        end
        rx = good_stop;
        repeat (BIT) @(negedge clk);
        rx = 1'b1;
        t_end = cyc;
    endtask

    task automatic write_pkt(input logic [15:0] a, input logic [31:0] d, input int gap);
        int w0;
        w0 = wr_cnt;
        send_frame(8'hCA, 1'b1); idle(gap);
        send_frame(a[15:8], 1'b1); idle(gap);
        send_frame(a[7:0], 1'b1); idle(gap);
        for (int k = 0; k < 4; k++) begin
            send_frame(d[8*k +: 8], 1'b1);
            idle(gap);
        end
        idle(PGAP);
        chk(wr_cnt == w0 + 1, "R3 write strobe count", wr_cnt, w0 + 1);
        chk(wr_addr_seen == a, "R3 write address", wr_addr_seen, a);
        chk(wr_data_seen == d, "R3 write data LSB-first", wr_data_seen, d);
        chk(last_op == 2'd2 && last_addr == a && last_data == d, "R9 write record",
            {last_op, last_addr, last_data}, {2'd2, a, d});
    endtask

    task automatic read_pkt(input logic [15:0] a, input int gap);
        int r0;
        logic [31:0] got;
        r0 = rd_cnt;
        tx_n = 0;
        tx_stop_ok = 1'b1;
        send_frame(8'h35, 1'b1); idle(gap);
        send_frame(a[15:8], 1'b1); idle(gap);
        send_frame(a[7:0], 1'b1);
        idle(4 * 10 * BIT + 100 + PGAP);
        got = {tx_bytes[3], tx_bytes[2], tx_bytes[1], tx_bytes[0]};
        chk(rd_cnt == r0 + 1, "R2 read strobe count", rd_cnt, r0 + 1);
        chk(rd_addr_seen == a, "R2 read address", rd_addr_seen, a);
        chk(tx_n == 4, "R5 response frame count", tx_n, 4);
        chk(got == model(a), "R5 response data LSB byte first", got, model(a));
        chk(tx_stop_ok, "R1 response stop bits high", tx_stop_ok, 1);
        chk(tx_first <= t_end + BIT, "R5 response latency", tx_first, t_end + BIT);
        chk(last_op == 2'd1 && last_addr == a && last_data == model(a), "R9 read record",
            {last_op, last_addr, last_data}, {2'd1, a, model(a)});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int w0, r0;
        logic [1:0]  op0;
        logic [15:0] a0;
        logic [31:0] d0;
        repeat (4) @(negedge clk);
        chk(tx === 1'b1 && reg_wr === 1'b0 && reg_rd === 1'b0, "R10 reset outputs",
            {tx, reg_wr, reg_rd}, 3'b100);
        chk(last_op === 2'd0 && last_addr === 16'h0 && last_data === 32'h0, "R10 reset record",
            {last_op, last_addr, last_data}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(tx === 1'b1 && last_op === 2'd0, "R10 state after reset", {tx, last_op}, 3'b100);
        idle(50);

        // R3 / R9: sweep of addresses and data words
        for (int i = 0; i < 6; i++) begin
            write_pkt(16'h0101 * (i + 1) ^ 16'h8000, 32'h1234_5678 * (i + 3) + i, 20);
        end
        // R2 / R5: sweep of reads
        for (int i = 0; i < 6; i++) begin
            read_pkt(16'h1357 * (i + 1), 20);
        end

        // R7: gaps just under the timeout keep the packet alive
        write_pkt(16'hBEEF, 32'hA5A5_0FF0, T1 - 60);
        read_pkt(16'h0F0F, T1 - 60);

        // R4: every invalid opcode value, one frame each
        w0 = wr_cnt; r0 = rd_cnt; op0 = last_op; a0 = last_addr; d0 = last_data;
        tx_n = 0;
        for (int v = 0; v < 256; v++) begin
            if (v != 8'h35 && v != 8'hCA) begin
                send_frame(v[7:0], 1'b1);
                idle(20);
            end
        end
        idle(PGAP);
        chk(wr_cnt == w0 && rd_cnt == r0, "R4 invalid opcodes no strobe", {wr_cnt, rd_cnt}, {w0, r0});
        chk(last_op == op0 && last_addr == a0 && last_data == d0, "R4 record unchanged",
            {last_op, last_addr}, {op0, a0});
        chk(tx_n == 0, "R4 no response", tx_n, 0);
        // R4: after an invalid opcode, a valid packet is accepted from its first frame
        send_frame(8'h5C, 1'b1); idle(30);
        read_pkt(16'h2468, 20);

        // R6: timeout after the address-high frame
        w0 = wr_cnt;
        send_frame(8'hCA, 1'b1); idle(20);
        send_frame(8'h12, 1'b1); idle(T1 + 80);
        read_pkt(16'h4321, 20);
        chk(wr_cnt == w0, "R6 abandoned write after address", wr_cnt, w0);

        // R6: timeout in the middle of the data bytes
        w0 = wr_cnt; op0 = last_op; a0 = last_addr; d0 = last_data;
        send_frame(8'hCA, 1'b1); idle(20);
        send_frame(8'h77, 1'b1); idle(20);
        send_frame(8'h66, 1'b1); idle(20);
        send_frame(8'h11, 1'b1); idle(20);
        send_frame(8'h22, 1'b1); idle(T1 + 80);
        idle(PGAP);
        chk(wr_cnt == w0, "R6 abandoned write in data", wr_cnt, w0);
        chk(last_op == op0 && last_addr == a0 && last_data == d0, "R6 record unchanged",
            {last_op, last_addr}, {op0, a0});
        write_pkt(16'h7766, 32'hCAFE_F00D, 20);

        // R8: framing error on the opcode frame, then a valid packet
        send_frame(8'h35, 1'b0); idle(60);
        write_pkt(16'h0042, 32'h0BAD_CAB1, 20);

        // R8: framing error on the address-low frame of a read
        r0 = rd_cnt; op0 = last_op; a0 = last_addr; d0 = last_data;
        tx_n = 0;
        send_frame(8'h35, 1'b1); idle(20);
        send_frame(8'h9A, 1'b1); idle(20);
        send_frame(8'hBC, 1'b0); idle(PGAP);
        chk(rd_cnt == r0 && tx_n == 0, "R8 framing error no read", {rd_cnt, tx_n}, {r0, 0});
        chk(last_op == op0 && last_addr == a0 && last_data == d0, "R8 record unchanged",
            {last_op, last_addr}, {op0, a0});

        // R8: framing error on the last data byte of a write
        w0 = wr_cnt;
        send_frame(8'hCA, 1'b1); idle(20);
        send_frame(8'h01, 1'b1); idle(20);
        send_frame(8'h02, 1'b1); idle(20);
        for (int k = 0; k < 3; k++) begin
            send_frame(8'h10 + k[7:0], 1'b1);
            idle(20);
        end
        send_frame(8'h13, 1'b0); idle(PGAP);
        chk(wr_cnt == w0, "R8 framing error no write", wr_cnt, w0);
        read_pkt(16'h0102, 20);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule